// File: doc/BRIEF.md
# Serial Gain-Word Receiver and Latch

This block is the digital control front end of a programmable-gain cable line driver. A host writes an 8-bit gain word over three wires: a serial clock, an active-low select and serial data. The block oversamples all three wires in a fast system clock domain and shifts data bits in while select is low. On the rising edge of select, it moves the word into a parallel gain latch. The latched code is clamped to the legal range and also presented as a signed gain in dB for the attenuator decoder.

Selecting the device with a falling edge freezes the gain that is in use and starts a new load. Deselecting commits the word and locks out shifting. A word that was not exactly eight bits long is still committed, using the last eight bits received, and a sticky error flag records the bad length.

Two asynchronous power inputs are merged into one-hot power-state outputs: full power-down, transmit standby, or active transmission. All control and status pins are plain levels. No word stream crosses the block's edge, so there is no valid/ready handshake and no back-pressure. The system clock must be at least four times the serial clock rate.

Top module: `gain_serial_rx`

## Requirements
- R1: The gain word is 8 bits wide and is sent most significant bit first. The first bit clocked in ends up as bit 7 of `gain_code`.
- R2: A data bit is taken only on a rising edge of `ser_clk` while `ser_sel_n` is low. Serial clock pulses while `ser_sel_n` is high leave the shift register unchanged.
- R3: While `ser_sel_n` is low, including partway through a load, `gain_code` keeps the previously committed value.
- R4: A rising edge of `ser_sel_n` copies the shift register into `gain_code`, and shifting stops until the next falling edge.
- R5: After reset, `gain_code` is 1, `dec_code` is 1, `gain_db` is -28, and `code_oor` and `count_err` are 0.
- R6: `gain_db` is a two's-complement value equal to `dec_code` minus 29. Code 1 gives -28 and code 60 gives +31.
- R7: A `gain_code` of 0 gives `dec_code` 1. A `gain_code` above 60 gives `dec_code` 60. In both cases `code_oor` is 1. Codes 1 to 60 pass through unchanged with `code_oor` at 0.
- R8: If `ser_sel_n` rises after fewer or more than 8 data bits, the last 8 bits shifted in are committed and `count_err` is set. `count_err` stays set until the next falling edge of `ser_sel_n`, which clears it.
- R9: When `power_on` is 0, `amp_off` is 1 and the other two states are 0, whatever `xmit_en` is. This path is combinational and needs no clock.
- R10: When `power_on` is 1, `xmit_en` = 0 gives `amp_standby` and `xmit_en` = 1 gives `amp_active`. Exactly one power-state output is high at any time. This path is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Serial clock; data is sampled on its rising edge |
| ser_sel_n | input | 1 | Active-low select; its rising edge commits the word |
| ser_dat | input | 1 | Serial data, most significant bit first |
| xmit_en | input | 1 | 1 enables forward transmission, 0 gives standby |
| power_on | input | 1 | 0 forces full power-down |
| gain_code | output | 8 | Committed raw gain code |
| dec_code | output | 8 | Gain code clamped to 1..60 for the decoder |
| gain_db | output | 9 | Signed gain in dB, equal to dec_code - 29 |
| code_oor | output | 1 | Committed code lies outside 1..60 |
| count_err | output | 1 | Sticky flag: the last load was not 8 bits long |
| amp_active | output | 1 | Amplifier transmitting |
| amp_standby | output | 1 | Awake but transmission disabled |
| amp_off | output | 1 | Full power-down |

## Verification
The assertions check the following on every cycle:
- the committed code changes only right after a select rising edge;
- the shift register moves only on a qualified serial clock edge;
- the clamped code stays in range and the dB value tracks it;
- the error flag rises only at a commit and clears after a select falling edge;
- the power states stay one-hot.

Only the bench scenarios can show the following:
- the bit order of a whole word;
- that stray clocks while deselected are ignored, seen through the bits of a later short load;
- which eight bits survive a long load;
- that the power outputs follow their inputs with no clock edge at all.

// File: rtl/gsr_pkg.sv
`timescale 1ns/1ps
package gsr_pkg;
  localparam int GSR_WORD_W   = 8;
  localparam int GSR_CODE_MIN = 1;
  localparam int GSR_CODE_MAX = 60;
  localparam int GSR_DB_OFS   = 29;

  typedef enum logic [1:0] {
    PM_OFF     = 2'd0,
    PM_STANDBY = 2'd1,
    PM_ACTIVE  = 2'd2
  } pmode_t;
endpackage

// File: rtl/gsr_sync_edge.sv
`timescale 1ns/1ps
module gsr_sync_edge #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] pipe [STAGES];
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
      prev <= RST_VAL;
    end else begin
      pipe[0] <= din;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      prev <= pipe[STAGES-1];
    end
  end

  assign lvl  = pipe[STAGES-1];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/gsr_word_shifter.sv
`timescale 1ns/1ps
module gsr_word_shifter #(
  parameter int WORD_W    = 8,
  parameter int RESET_CODE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_lvl,
  input  logic              en_rise,
  input  logic              en_fall,
  input  logic              sck_rise,
  input  logic              dat_lvl,
  output logic [WORD_W-1:0] shreg,
  output logic [WORD_W-1:0] latched,
  output logic              count_err
);
  localparam int CNT_W   = $clog2(WORD_W + 2);
  localparam int CNT_SAT = WORD_W + 1;

  logic [CNT_W-1:0] bit_cnt;
  logic             shift_now;

  assign shift_now = sck_rise && !en_lvl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg     <= '0;
      bit_cnt   <= '0;
      latched   <= WORD_W'(RESET_CODE);
      count_err <= 1'b0;
    end else begin
      if (en_fall) begin
        bit_cnt   <= '0;
        count_err <= 1'b0;
      end else if (shift_now) begin
        shreg <= {shreg[WORD_W-2:0], dat_lvl};
        if (bit_cnt != CNT_W'(CNT_SAT)) bit_cnt <= bit_cnt + 1'b1;
      end
      if (en_rise) begin
        latched   <= shreg;
        count_err <= (bit_cnt != CNT_W'(WORD_W));
      end
    end
  end
endmodule

// File: rtl/gsr_gain_map.sv
`timescale 1ns/1ps
module gsr_gain_map #(
  parameter int WORD_W   = 8,
  parameter int CODE_MIN = 1,
  parameter int CODE_MAX = 60,
  parameter int DB_OFS   = 29
) (
  input  logic [WORD_W-1:0]        code,
  output logic [WORD_W-1:0]        dec_code,
  output logic signed [WORD_W:0]   gain_db,
  output logic                     code_oor
);
  logic below, above;

  assign below    = code < WORD_W'(CODE_MIN);
  assign above    = code > WORD_W'(CODE_MAX);
  assign code_oor = below | above;

  always_comb begin
    if (below)      dec_code = WORD_W'(CODE_MIN);
    else if (above) dec_code = WORD_W'(CODE_MAX);
    else            dec_code = code;
  end

  assign gain_db = $signed({1'b0, dec_code}) - $signed((WORD_W+1)'(DB_OFS));
endmodule

// File: rtl/gsr_power_ctl.sv
`timescale 1ns/1ps
module gsr_power_ctl
  import gsr_pkg::*;
(
  input  logic xmit_en,
  input  logic power_on,
  output logic amp_active,
  output logic amp_standby,
  output logic amp_off
);
  pmode_t mode;

  always_comb begin
    if (!power_on)     mode = PM_OFF;
    else if (!xmit_en) mode = PM_STANDBY;
    else               mode = PM_ACTIVE;
  end

  assign amp_off     = (mode == PM_OFF);
  assign amp_standby = (mode == PM_STANDBY);
  assign amp_active  = (mode == PM_ACTIVE);
endmodule

// File: rtl/gain_serial_rx.sv
`timescale 1ns/1ps
module gain_serial_rx
  import gsr_pkg::*;
#(
  parameter int WORD_W      = GSR_WORD_W,
  parameter int CODE_MIN    = GSR_CODE_MIN,
  parameter int CODE_MAX    = GSR_CODE_MAX,
  parameter int DB_OFS      = GSR_DB_OFS,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ser_clk,
  input  logic                    ser_sel_n,
  input  logic                    ser_dat,
  input  logic                    xmit_en,
  input  logic                    power_on,
  output logic [WORD_W-1:0]       gain_code,
  output logic [WORD_W-1:0]       dec_code,
  output logic signed [WORD_W:0]  gain_db,
  output logic                    code_oor,
  output logic                    count_err,
  output logic                    amp_active,
  output logic                    amp_standby,
  output logic                    amp_off
);
  localparam int PIN_SEL = 2;
  localparam int PIN_CLK = 1;
  localparam int PIN_DAT = 0;

  logic [2:0]        pin_lvl, pin_rise, pin_fall;
  logic              en_lvl, en_rise, en_fall, sck_rise;
  logic [WORD_W-1:0] shreg;

  gsr_sync_edge #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk (clk), .rst_n (rst_n),
    .din ({ser_sel_n, ser_clk, ser_dat}),
    .lvl (pin_lvl), .rise (pin_rise), .fall (pin_fall)
  );

  assign en_lvl   = pin_lvl[PIN_SEL];
  assign en_rise  = pin_rise[PIN_SEL];
  assign en_fall  = pin_fall[PIN_SEL];
  assign sck_rise = pin_rise[PIN_CLK];

  gsr_word_shifter #(.WORD_W(WORD_W), .RESET_CODE(CODE_MIN)) u_shift (
    .clk (clk), .rst_n (rst_n),
    .en_lvl (en_lvl), .en_rise (en_rise), .en_fall (en_fall),
    .sck_rise (sck_rise), .dat_lvl (pin_lvl[PIN_DAT]),
    .shreg (shreg), .latched (gain_code), .count_err (count_err)
  );

  gsr_gain_map #(.WORD_W(WORD_W), .CODE_MIN(CODE_MIN), .CODE_MAX(CODE_MAX),
                 .DB_OFS(DB_OFS)) u_map (
    .code (gain_code), .dec_code (dec_code), .gain_db (gain_db),
    .code_oor (code_oor)
  );

  gsr_power_ctl u_pwr (
    .xmit_en (xmit_en), .power_on (power_on),
    .amp_active (amp_active), .amp_standby (amp_standby), .amp_off (amp_off)
  );
endmodule

// File: rtl/gsr_checker.sv
`timescale 1ns/1ps
module gsr_checker #(
  parameter int WORD_W   = 8,
  parameter int CODE_MIN = 1,
  parameter int CODE_MAX = 60,
  parameter int DB_OFS   = 29
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   en_lvl,
  input logic                   en_rise,
  input logic                   en_fall,
  input logic                   sck_rise,
  input logic [WORD_W-1:0]      shreg,
  input logic [WORD_W-1:0]      gain_code,
  input logic [WORD_W-1:0]      dec_code,
  input logic signed [WORD_W:0] gain_db,
  input logic                   code_oor,
  input logic                   count_err,
  input logic                   amp_active,
  input logic                   amp_standby,
  input logic                   amp_off,
  input logic                   power_on,
  input logic                   xmit_en
);
  assert_shift_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(shreg) |-> $past(sck_rise && !en_lvl));

  assert_gain_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gain_code) |-> $past(en_rise));

  assert_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise |=> (gain_code == $past(shreg)));

  assert_db_track_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_db + $signed((WORD_W+1)'(DB_OFS))) == $signed({1'b0, dec_code}));

  assert_clamp_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_code >= WORD_W'(CODE_MIN)) && (dec_code <= WORD_W'(CODE_MAX)));

  assert_oor_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    code_oor |-> (dec_code == WORD_W'(CODE_MIN) || dec_code == WORD_W'(CODE_MAX)));

  assert_err_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(count_err) |-> $past(en_rise));

  assert_err_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    en_fall |=> !count_err);

  assert_power_down_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !power_on |-> (amp_off && !amp_active && !amp_standby));

  assert_one_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({amp_active, amp_standby, amp_off}) == 1);

  assert_standby_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (power_on && !xmit_en) |-> amp_standby);
endmodule

bind gain_serial_rx gsr_checker #(
  .WORD_W(WORD_W), .CODE_MIN(CODE_MIN), .CODE_MAX(CODE_MAX), .DB_OFS(DB_OFS)
) u_chk (.*);

// File: tb/gain_serial_rx_test.sv
`timescale 1ns/1ps
module gain_serial_rx_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_sel_n = 1'b1, ser_dat = 1'b0;
  logic xmit_en = 1'b0, power_on = 1'b0;
  logic [7:0]        gain_code, dec_code;
  logic signed [8:0] gain_db;
  logic code_oor, count_err, amp_active, amp_standby, amp_off;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  gain_serial_rx uut (
    .clk (clk), .rst_n (rst_n), .ser_clk (ser_clk), .ser_sel_n (ser_sel_n),
    .ser_dat (ser_dat), .xmit_en (xmit_en), .power_on (power_on),
    .gain_code (gain_code), .dec_code (dec_code), .gain_db (gain_db),
    .code_oor (code_oor), .count_err (count_err), .amp_active (amp_active),
    .amp_standby (amp_standby), .amp_off (amp_off)
  );

  // {sent code, expected dec_code, expected dB (signed 8), expected oor}
  localparam int NVEC = 8;
  localparam logic [24:0] VEC [NVEC] = '{
    {8'd1,   8'd1,  8'hE4, 1'b0},
    {8'd60,  8'd60, 8'd31, 1'b0},
    {8'd30,  8'd30, 8'd1,  1'b0},
    {8'd29,  8'd29, 8'd0,  1'b0},
    {8'd0,   8'd1,  8'hE4, 1'b1},
    {8'd61,  8'd60, 8'd31, 1'b1},
    {8'd255, 8'd60, 8'd31, 1'b1},
    {8'hA5,  8'd60, 8'd31, 1'b1}
  };

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    ser_dat = b;   wait_clk(4);
    ser_clk = 1'b1; wait_clk(4);
    ser_clk = 1'b0;
  endtask

  task automatic sel_low();
    ser_sel_n = 1'b0; wait_clk(6);
  endtask

  task automatic sel_high();
    wait_clk(4); ser_sel_n = 1'b1; wait_clk(8);
  endtask

  task automatic frame(input logic [15:0] w, input int n);
    sel_low();
    for (int i = n - 1; i >= 0; i--) bit_out(w[i]);
    sel_high();
  endtask

  task automatic pwr_case(input logic tx, input logic pw, input logic ea,
                          input logic es, input logic eo, input string req);
    @(negedge clk);
    #2;
    xmit_en = tx; power_on = pw;
    #1;
    check(amp_active == ea && amp_standby == es && amp_off == eo, req,
          {amp_active, amp_standby, amp_off}, {ea, es, eo});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(3);
    // R5 reset state
    check(gain_code == 8'd1, "R5 gain_code", gain_code, 1);
    check(dec_code == 8'd1 && gain_db == -9'sd28, "R5 dB", gain_db, -28);
    check(!code_oor && !count_err, "R5 flags", {code_oor, count_err}, 0);

    // R1 R6 R7 vector walk
    for (int k = 0; k < NVEC; k++) begin
      frame({8'h00, VEC[k][24:17]}, 8);
      check(gain_code == VEC[k][24:17], "R1 R4 code", gain_code, VEC[k][24:17]);
      check(dec_code == VEC[k][16:9], "R7 clamp", dec_code, VEC[k][16:9]);
      check(int'(gain_db) == int'($signed(VEC[k][8:1])), "R6 dB",
            int'(gain_db), int'($signed(VEC[k][8:1])));
      check(code_oor == VEC[k][0] && !count_err, "R7 oor", code_oor, VEC[k][0]);
    end

    // R3 gain held during a load, R4 committed on rise
    sel_low();
    for (int i = 7; i >= 4; i--) bit_out(8'h2A >> i);
    wait_clk(6);
    check(gain_code == 8'hA5, "R3 hold mid-load", gain_code, 8'hA5);
    for (int i = 3; i >= 0; i--) bit_out(8'h2A >> i);
    wait_clk(6);
    check(gain_code == 8'hA5, "R3 hold before rise", gain_code, 8'hA5);
    sel_high();
    check(gain_code == 8'h2A && gain_db == 9'sd13, "R4 commit", gain_code, 8'h2A);

    // R2 clocks while deselected are ignored, seen via a short load
    frame(16'h003C, 8);
    for (int i = 0; i < 8; i++) begin
      ser_dat = 1'b1; wait_clk(4); ser_clk = 1'b1; wait_clk(4); ser_clk = 1'b0;
    end
    wait_clk(4);
    check(gain_code == 8'h3C, "R2 no commit while high", gain_code, 8'h3C);
    frame(16'h0005, 3);
    check(gain_code == 8'hE5, "R2 R8 short load", gain_code, 8'hE5);
    check(count_err == 1'b1, "R8 short sets err", count_err, 1);

    // R8 long load keeps last 8 bits; cleared by next falling edge
    frame(16'h0217, 10);
    check(gain_code == 8'h17, "R8 long load", gain_code, 8'h17);
    check(count_err == 1'b1, "R8 long sets err", count_err, 1);
    sel_low();
    check(count_err == 1'b0, "R8 cleared on fall", count_err, 0);
    check(gain_code == 8'h17, "R3 hold after fall", gain_code, 8'h17);
    for (int i = 7; i >= 0; i--) bit_out(8'h3B >> i);
    sel_high();
    check(gain_code == 8'h3B && !count_err, "R8 good load no err", gain_code, 8'h3B);

    // R9 R10 asynchronous power outputs
    pwr_case(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R10 active");
    pwr_case(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R10 standby");
    pwr_case(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R9 off with tx high");
    pwr_case(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R9 off with tx low");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule